// File: doc/BRIEF.md
# Triggered Probe Capture Engine

This block records a bus of probe signals into an on-chip circular sample memory so that on-chip logic can be inspected around an event of interest. Every probe bit is registered on every clock. Once armed, the engine keeps writing samples into the ring until a trigger occurs. It then collects a programmable number of further samples and freezes the buffer. The trigger is either a rising or falling edge on one selectable probe bit, or a forced command that needs no probe condition.

The caller sets how many samples must come before the trigger. A build parameter can instead fix that depth at half the buffer. After a capture completes, a readout port returns the frozen window oldest sample first. In continuous mode the engine arms itself again as soon as the previous window has been drained, so captures repeat without further commands.

Top module: `la_capture_core`

## Requirements
- R1: After reset the state output is 0 (idle), done is low and no read data is valid. While idle and without an arm or force command the engine stays idle whatever the probes do, and read requests are ignored.
- R2: An arm command in the idle or done state moves the state output to 1 (waiting) on the next clock and restarts sample writing at address 0. The engine stays in state 1 for as long as no trigger is accepted.
- R3: The trigger is accepted when the selected probe bit (select 0 is bit 0) differs between the newest registered sample and the one before it. With the falling select at 0 this means 0 to 1; with it at 1 it means 1 to 0.
- R4: An edge is ignored while fewer samples than the pre-trigger depth have been written since arming.
- R5: The trigger address output holds the buffer address of the trigger sample, counted from 0 at arming. It stays unchanged while in state 3.
- R6: The window holds exactly DEPTH samples, pre-trigger depth of them before the trigger sample. The state output goes to 3 (done) and done goes high on the clock after the last sample of the window has been written. State 2 marks collection after the trigger.
- R7: In state 3, each read request returns the next sample of the window one clock later with read-valid high, starting with the oldest. Read-last marks the final sample, after which the engine leaves state 3. Read data is never valid outside this.
- R8: A force command in state 1 takes the sample being written in that cycle as the trigger. It ignores the edge condition, and the effective pre-trigger depth is the lesser of the programmed depth and the samples already written.
- R9: A force command in the idle or done state starts collection at once (state 2, trigger address 0). The window is then the next DEPTH samples, with none before the trigger.
- R10: With continuous mode high when the final sample is read, the engine returns to state 1 and waits for a new trigger. With it low, it returns to state 0.
- R11: An arm command in state 3 abandons the unread window, drops done and returns to state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture and readout clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_i | input | PROBE_W | Probe signals sampled every clock |
| arm_i | input | 1 | Arm command |
| force_i | input | 1 | Forced trigger command |
| cont_i | input | 1 | Continuous mode: re-arm after readout |
| trig_sel_i | input | SEL_W | Index of the probe bit watched for an edge |
| trig_fall_i | input | 1 | 0: rising edge, 1: falling edge |
| pre_depth_i | input | AW | Samples kept before the trigger (0 to DEPTH-1) |
| rd_en_i | input | 1 | Read request for the next stored sample |
| state_o | output | 2 | 0 idle, 1 waiting, 2 post-trigger, 3 done |
| done_o | output | 1 | High while a frozen window awaits readout |
| trig_addr_o | output | AW | Buffer address of the trigger sample |
| rd_data_o | output | PROBE_W | Read sample |
| rd_valid_o | output | 1 | Read data valid |
| rd_last_o | output | 1 | Read sample is the last of the window |

## Verification
A probe value driven before clock edge k is registered at k and written at k+1. An edge trigger on sample m therefore raises done on the edge after sample m - pre + DEPTH has been written, and the bench expects the done state at exactly that cycle. A forced trigger in the waiting state takes the sample registered one cycle earlier. A forced start from idle writes its first sample one edge after the command. Read data appears one edge after each accepted request. The bench drives every input on the falling edge and reads every output at the next falling edge. It keeps a history of driven probe values and, for each scenario, searches that history for the first qualifying edge.

// File: rtl/la_pkg.sv
package la_pkg;
   typedef enum logic [1:0] {
      LA_IDLE = 2'd0,
      LA_WAIT = 2'd1,
      LA_POST = 2'd2,
      LA_DONE = 2'd3
   } la_state_e;
endpackage

// File: rtl/la_edge_det.sv
module la_edge_det #(
   parameter int W    = 8,
   parameter int SW   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  smp_i,
   input  logic [SW-1:0] sel_i,
   input  logic          fall_i,
   output logic          edge_o
);
   logic [W-1:0] prev_q;
   logic         cur_b, old_b;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= smp_i;
   end

   assign cur_b  = smp_i[sel_i];
   assign old_b  = prev_q[sel_i];
   assign edge_o = fall_i ? (old_b & ~cur_b) : (~old_b & cur_b);
endmodule

// File: rtl/la_sample_ram.sv
module la_sample_ram #(
   parameter int W     = 8,
   parameter int DEPTH = 1024,
   parameter int AW    = 10
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [W-1:0]  wdata_i,
   input  logic          re_i,
   input  logic [AW-1:0] raddr_i,
   output logic [W-1:0]  rdata_o
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
      if (re_i) rdata_o      <= mem[raddr_i];
   end
endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
   import la_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int AW    = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm_i,
   input  logic          force_i,
   input  logic          cont_i,
   input  logic          edge_i,
   input  logic [AW-1:0] pre_i,
   input  logic          rd_en_i,
   output la_state_e     state_o,
   output logic          we_o,
   output logic [AW-1:0] waddr_o,
   output logic          re_o,
   output logic [AW-1:0] raddr_o,
   output logic          rd_last_o,
   output logic [AW-1:0] trig_addr_o
);
   localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

   la_state_e     state_q;
   logic [AW-1:0] wr_ptr_q, fill_q, pre_q, trig_q, rd_ptr_q, rd_cnt_q;
   logic [AW:0]   left_q, left_after;
   logic [AW-1:0] eff_pre;
   logic          hit, idle_like;

   assign idle_like  = (state_q == LA_IDLE) || (state_q == LA_DONE);
   assign eff_pre    = (fill_q < pre_q) ? fill_q : pre_q;
   assign hit        = (state_q == LA_WAIT) &&
                       (force_i || (edge_i && (fill_q >= pre_q)));
   assign left_after = FULL_CNT - (AW+1)'(1) - {1'b0, eff_pre};
   assign re_o       = (state_q == LA_DONE) && rd_en_i && !arm_i && !force_i;
   assign rd_last_o  = re_o && (rd_cnt_q == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= LA_IDLE;
         wr_ptr_q <= '0;
         fill_q   <= '0;
         pre_q    <= '0;
         trig_q   <= '0;
         rd_ptr_q <= '0;
         rd_cnt_q <= '0;
         left_q   <= '0;
      end else begin
         unique case (state_q)
            LA_IDLE, LA_DONE: begin
               if (force_i) begin
                  state_q  <= LA_POST;
                  wr_ptr_q <= '0;
                  fill_q   <= '0;
                  trig_q   <= '0;
                  rd_ptr_q <= '0;
                  rd_cnt_q <= '0;
                  left_q   <= FULL_CNT;
               end else if (arm_i) begin
                  state_q  <= LA_WAIT;
                  wr_ptr_q <= '0;
                  fill_q   <= '0;
                  pre_q    <= pre_i;
                  rd_cnt_q <= '0;
               end else if (re_o) begin
                  rd_ptr_q <= rd_ptr_q + AW'(1);
                  rd_cnt_q <= rd_cnt_q + AW'(1);
                  if (rd_last_o) begin
                     if (cont_i) begin
                        state_q  <= LA_WAIT;
                        wr_ptr_q <= '0;
                        fill_q   <= '0;
                        pre_q    <= pre_i;
                        rd_cnt_q <= '0;
                     end else begin
                        state_q  <= LA_IDLE;
                     end
                  end
               end
            end
            LA_WAIT: begin
               wr_ptr_q <= wr_ptr_q + AW'(1);
               if (hit) begin
                  trig_q   <= wr_ptr_q;
                  rd_ptr_q <= wr_ptr_q - eff_pre;
                  rd_cnt_q <= '0;
                  left_q   <= left_after;
                  state_q  <= (left_after == '0) ? LA_DONE : LA_POST;
               end else if (fill_q != LAST_IDX) begin
                  fill_q   <= fill_q + AW'(1);
               end
            end
            LA_POST: begin
               wr_ptr_q <= wr_ptr_q + AW'(1);
               left_q   <= left_q - (AW+1)'(1);
               if (left_q == (AW+1)'(1)) state_q <= LA_DONE;
            end
            default: state_q <= LA_IDLE;
         endcase
      end
   end

   assign state_o     = state_q;
   assign we_o        = (state_q == LA_WAIT) || (state_q == LA_POST);
   assign waddr_o     = wr_ptr_q;
   assign raddr_o     = rd_ptr_q;
   assign trig_addr_o = trig_q;

   logic unused_ok;
   assign unused_ok = idle_like;
endmodule

// File: rtl/la_capture_core.sv
module la_capture_core
   import la_pkg::*;
#(
   parameter int PROBE_W  = 8,
   parameter int DEPTH    = 1024,
   parameter bit PRE_PROG = 1'b1,
   localparam int AW      = $clog2(DEPTH),
   localparam int SEL_W   = (PROBE_W > 1) ? $clog2(PROBE_W) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PROBE_W-1:0] probe_i,
   input  logic               arm_i,
   input  logic               force_i,
   input  logic               cont_i,
   input  logic [SEL_W-1:0]   trig_sel_i,
   input  logic               trig_fall_i,
   input  logic [AW-1:0]      pre_depth_i,
   input  logic               rd_en_i,
   output logic [1:0]         state_o,
   output logic               done_o,
   output logic [AW-1:0]      trig_addr_o,
   output logic [PROBE_W-1:0] rd_data_o,
   output logic               rd_valid_o,
   output logic               rd_last_o
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("la_capture_core: DEPTH must be a power of two, at least 4");
   end
   if (PROBE_W < 2) begin : g_bad_width
      $error("la_capture_core: PROBE_W must be at least 2");
   end

   logic [PROBE_W-1:0] probe_q;
   logic [AW-1:0]      pre_src, waddr, raddr;
   logic               edge_hit, we, re, last_rd;
   la_state_e          state;
   logic               rd_valid_q, rd_last_q;

   if (PRE_PROG) begin : g_pre_port
      assign pre_src = pre_depth_i;
   end else begin : g_pre_half
      assign pre_src = AW'(DEPTH / 2);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) probe_q <= '0;
      else        probe_q <= probe_i;
   end

   la_edge_det #(.W(PROBE_W), .SW(SEL_W)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_i  (probe_q),
      .sel_i  (trig_sel_i),
      .fall_i (trig_fall_i),
      .edge_o (edge_hit)
   );

   la_capture_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm_i       (arm_i),
      .force_i     (force_i),
      .cont_i      (cont_i),
      .edge_i      (edge_hit),
      .pre_i       (pre_src),
      .rd_en_i     (rd_en_i),
      .state_o     (state),
      .we_o        (we),
      .waddr_o     (waddr),
      .re_o        (re),
      .raddr_o     (raddr),
      .rd_last_o   (last_rd),
      .trig_addr_o (trig_addr_o)
   );

   la_sample_ram #(.W(PROBE_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
      .clk     (clk),
      .we_i    (we),
      .waddr_i (waddr),
      .wdata_i (probe_q),
      .re_i    (re),
      .raddr_i (raddr),
      .rdata_o (rd_data_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_last_q  <= 1'b0;
      end else begin
         rd_valid_q <= re;
         rd_last_q  <= last_rd;
      end
   end

   assign state_o    = state;
   assign done_o     = (state == LA_DONE);
   assign rd_valid_o = rd_valid_q;
   assign rd_last_o  = rd_last_q;
endmodule

// File: rtl/la_capture_chk.sv
module la_capture_chk #(
   parameter int AW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          arm_i,
   input logic          force_i,
   input logic [1:0]    state_o,
   input logic          done_o,
   input logic          rd_valid_o,
   input logic          rd_last_o,
   input logic [AW-1:0] trig_addr_o
);
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && !arm_i && !force_i) |=> (state_o == 2'd0)); // R1
   AST_ARM_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_o == 2'd0 || state_o == 2'd3) && arm_i && !force_i) |=> (state_o == 2'd1)); // R2
   AST_FORCE_START: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_o == 2'd0 || state_o == 2'd3) && force_i) |=> (state_o == 2'd2 && trig_addr_o == '0)); // R9
   AST_READ_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> ($past(state_o) == 2'd3)); // R7
   AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last_o |-> rd_valid_o); // R7
   AST_DONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ($past(state_o) == 2'd1 || $past(state_o) == 2'd2)); // R6
   AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd3 && $past(state_o) == 2'd3) |-> $stable(trig_addr_o)); // R5
endmodule

bind la_capture_core la_capture_chk #(.AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .arm_i       (arm_i),
   .force_i     (force_i),
   .state_o     (state_o),
   .done_o      (done_o),
   .rd_valid_o  (rd_valid_o),
   .rd_last_o   (rd_last_o),
   .trig_addr_o (trig_addr_o)
);

// File: tb/la_capture_core_test.sv
module la_capture_core_test;
   localparam int PW = 8;
   localparam int D  = 16;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] probe_i = '0;
   logic          arm_i = 0, force_i = 0, cont_i = 0, trig_fall_i = 0, rd_en_i = 0;
   logic [2:0]    trig_sel_i = '0;
   logic [AW-1:0] pre_depth_i = '0;
   logic [1:0]    state_o;
   logic          done_o, rd_valid_o, rd_last_o;
   logic [AW-1:0] trig_addr_o;
   logic [PW-1:0] rd_data_o;

   int total = 0, bad = 0;
   int cyc_n = 0, kbase = 0, t1 = 1000, t2 = 1000;
   logic lvl = 1'b0;
   logic [PW-1:0] hist [512];

   always #4 clk = ~clk;

   la_capture_core #(.PROBE_W(PW), .DEPTH(D)) uut (
      .clk(clk), .rst_n(rst_n), .probe_i(probe_i), .arm_i(arm_i), .force_i(force_i),
      .cont_i(cont_i), .trig_sel_i(trig_sel_i), .trig_fall_i(trig_fall_i),
      .pre_depth_i(pre_depth_i), .rd_en_i(rd_en_i), .state_o(state_o), .done_o(done_o),
      .trig_addr_o(trig_addr_o), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
      .rd_last_o(rd_last_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one clock: drive probes on the falling edge; bit0 is a scheduled pulse line
   task automatic step();
      int off;
      logic tl;
      @(negedge clk);
      cyc_n++;
      off = cyc_n - kbase;
      tl  = lvl ^ ((off >= t1 && off < t1 + 2) || (off >= t2 && off < t2 + 3));
      probe_i = {cyc_n[6:0], tl};
      hist[cyc_n % 512] = probe_i;
   endtask

   function automatic int find_m(input int k, input int pre, input int sel, input bit fall);
      for (int m = k + pre; m <= cyc_n; m++) begin
         logic pb, cb;
         pb = hist[(m - 1) % 512][sel];
         cb = hist[m % 512][sel];
         if (fall ? (pb && !cb) : (!pb && cb)) return m;
      end
      return -1;
   endfunction

   task automatic do_arm(output int k);
      step(); arm_i = 1; k = cyc_n; kbase = k;
      step(); arm_i = 0;
      chk(state_o == 2'd1, "R2 arm->wait", state_o, 1);
   endtask

   task automatic wait_done(input int ign_off, output int c);
      int n = 0;
      c = -1;
      while (state_o != 2'd3 && n < 100) begin
         step(); n++;
         if (ign_off > 0 && cyc_n - kbase == ign_off)
            chk(state_o == 2'd1, "R4 early edge ignored", state_o, 1);
      end
      if (state_o == 2'd3) c = cyc_n;
      chk(done_o == 1'b1, "R6 done high", done_o, 1);
   endtask

   task automatic readout(input int first, input int exp_after, output int last_c);
      rd_en_i = 1;
      for (int j = 0; j < D; j++) begin
         step();
         if (j == D - 1) rd_en_i = 0;
         chk(rd_valid_o && rd_data_o == hist[(first + j) % 512] && rd_last_o == (j == D - 1),
             "R7 readout order", rd_data_o, hist[(first + j) % 512]);
      end
      last_c = cyc_n;
      chk(state_o == 2'(exp_after), "R10 state after readout", state_o, exp_after);
   endtask

   task automatic edge_cap(input int pre, input int sel, input bit fall,
                           input int p1, input int p2, input int ign, input bit cont);
      int k, c, m, lc;
      pre_depth_i = AW'(pre); trig_sel_i = 3'(sel); trig_fall_i = fall;
      lvl = fall; t1 = p1; t2 = p2; cont_i = cont;
      do_arm(k);
      wait_done(ign, c);
      m = find_m(k, pre, sel, fall);
      chk(c == m - pre + D + 1, "R3 R6 done cycle", c, m - pre + D + 1);
      chk(trig_addr_o == AW'((m - k) % D), "R5 trigger address", trig_addr_o, (m - k) % D);
      readout(m - pre, cont ? 1 : 0, lc);
   endtask

   initial begin
      int k, c, f, fill, ep, lc, m;
      repeat (3) step();
      rst_n = 1;
      step();
      chk(state_o == 2'd0 && !done_o && !rd_valid_o, "R1 reset state", state_o, 0);
      kbase = cyc_n; t1 = 2; t2 = 5; rd_en_i = 1;
      for (int i = 0; i < 10; i++) step();
      chk(state_o == 2'd0 && !rd_valid_o, "R1 idle ignores probes and reads", state_o, 0);
      rd_en_i = 0; t1 = 1000; t2 = 1000;

      edge_cap(8, 0, 1'b0, 3, 12, 6, 1'b0);   // R4: pulse at 3 ignored
      edge_cap(0, 0, 1'b0, 5, 9, 0, 1'b0);
      edge_cap(D - 1, 1, 1'b0, 1000, 1000, 0, 1'b0);
      edge_cap(4, 0, 1'b1, 2, 10, 5, 1'b0);   // falling select
      edge_cap(5, 2, 1'b1, 1000, 1000, 0, 1'b0);

      // R2: waiting holds with no edge on the selected line
      pre_depth_i = AW'(8); trig_sel_i = 0; trig_fall_i = 0; lvl = 0; t1 = 1000; t2 = 1000;
      do_arm(k);
      for (int i = 0; i < 30; i++) step();
      chk(state_o == 2'd1, "R2 stays waiting", state_o, 1);
      // R8: forced trigger while waiting
      step(); force_i = 1; f = cyc_n;
      step(); force_i = 0;
      fill = (f - 1 - k > D - 1) ? D - 1 : f - 1 - k;
      ep = (fill < 8) ? fill : 8;
      wait_done(0, c);
      chk(c == f - 1 - ep + D + 1, "R8 forced done cycle", c, f - 1 - ep + D + 1);
      chk(trig_addr_o == AW'((f - 1 - k) % D), "R8 forced trig addr", trig_addr_o, (f - 1 - k) % D);
      readout(f - 1 - ep, 0, lc);

      // R8: forced soon after arming, fewer samples than programmed depth
      do_arm(k);
      step(); step(); force_i = 1; f = cyc_n;
      step(); force_i = 0;
      ep = f - 1 - k;
      wait_done(0, c);
      chk(c == f - 1 - ep + D + 1, "R8 short prefill done cycle", c, f - 1 - ep + D + 1);
      readout(f - 1 - ep, 0, lc);

      // R9: forced start from idle
      step(); force_i = 1; f = cyc_n;
      step(); force_i = 0;
      chk(state_o == 2'd2 && trig_addr_o == 0, "R9 force from idle", state_o, 2);
      wait_done(0, c);
      chk(c == f + D + 1, "R9 forced idle done cycle", c, f + D + 1);
      readout(f, 0, lc);

      // R11: arm while done abandons the window
      pre_depth_i = AW'(2); t1 = 4; t2 = 1000;
      do_arm(k);
      wait_done(0, c);
      step(); arm_i = 1; kbase = cyc_n;
      step(); arm_i = 0;
      chk(state_o == 2'd1 && !done_o, "R11 re-arm from done", state_o, 1);
      t1 = 1000;
      step(); force_i = 1;
      step(); force_i = 0;
      wait_done(0, c);
      step(); cont_i = 0;
      rd_en_i = 1;
      for (int j = 0; j < D; j++) step();
      rd_en_i = 0;
      step();

      // R10: continuous mode re-arms after the drain
      edge_cap(6, 0, 1'b0, 8, 1000, 0, 1'b1);
      k = cyc_n - 1; kbase = k; t1 = 9; t2 = 1000; cont_i = 0;
      wait_done(0, c);
      m = find_m(k, 6, 0, 1'b0);
      chk(c == m - 6 + D + 1, "R10 second capture done cycle", c, m - 6 + D + 1);
      readout(m - 6, 0, lc);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule